// File: doc/BRIEF.md
# LUT-Pair Sequential Element

This block holds the storage element that sits behind a pair of lookup-table cells, one even and one odd. Each pair has a 3-bit mode that picks one of four element kinds (D flip-flop with gate, JK flip-flop, gated D latch, set/reset latch) or leaves the element out. The even cell's output feeds the element's first input (D, J or S), and the odd cell's output feeds the second (gate G, K or R). The lookup-table cells and the clock selection are outside the block. The block takes their results as plain inputs: the two cell outputs and the even cell's selected clock as a level.

When a pair's element is active, the element output takes the place of the raw even-cell output on all four downstream nets: pin, feedback, link and event. When the mode is "off", those nets carry the even-cell output unchanged. The flip-flop kinds act on a rising edge of the even cell's clock, as seen at the block clock. The latch kinds are level-sensitive. While a latch is transparent, or while set or reset is asserted alone, its output follows the inputs with no register in the path. The number of pairs is a parameter, and each pair's mode, inputs and element are fully independent.

Top module: `lut_pair_seq`

## Requirements
- R1: After reset every element holds 0. A pair put in flip-flop mode straight out of reset drives 0 on its downstream nets until it captures.
- R2: Mode 1 (gated D flip-flop) loads the even input at a rising edge of the pair clock only while the odd input is 1. At any other edge, or with no edge, the output holds.
- R3: Mode 2 (JK flip-flop), at a rising edge of the pair clock: even=1 and odd=0 sets the output, even=0 and odd=1 clears it, both 1 inverts it, and both 0 holds it.
- R4: Mode 3 (gated D latch) copies the even input to the output in the same cycle, with no clock edge, while the odd input is 1. It keeps the last value while the odd input is 0.
- R5: Mode 4 (set/reset latch) drives 1 as soon as even=1 with odd=0 and drives 0 as soon as odd=1 with even=0, with no clock involved.
- R6: In mode 4 with both even and odd at 1, the output keeps its previous value.
- R7: Mode 0, and the unused codes 5, 6 and 7, leave the element out. The four downstream nets then equal the raw even input.
- R8: While modes 1 to 4 are selected, the pin, feedback, link and event nets all carry the element output and not the even input.
- R9: A block-clock cycle in which a pair's mode differs from its mode in the previous cycle clears that element to 0. This clear overrides a pair-clock edge in the same cycle.
- R10: Each pair's mode and inputs affect only that pair's outputs.
- R11: A pair-clock rising edge is recognised only when the pair clock was 0 at one block-clock edge and 1 at the next. A pair clock held at 1 gives no further capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample pair clocks and hold element state |
| rst_n | input | 1 | Active-low asynchronous reset |
| seqMode | input | 3*PAIR_COUNT | Per-pair mode code, pair p in bits [3p+2:3p] |
| evenLut | input | PAIR_COUNT | Even cell output per pair (D, J or S) |
| oddLut | input | PAIR_COUNT | Odd cell output per pair (G, K or R) |
| lutClk | input | PAIR_COUNT | Selected clock of the even cell, per pair, as a level |
| pinOut | output | PAIR_COUNT | Net toward the output pin |
| fbOut | output | PAIR_COUNT | Net toward the feedback input |
| linkOut | output | PAIR_COUNT | Net toward the neighbour's link input |
| evtOut | output | PAIR_COUNT | Net toward the event output |

## Verification
Two of this block's functions can act in one cycle: a mode-change clear and a flip-flop capture on a pair-clock rising edge. The bench provokes this deliberately. It switches a pair that holds 1 into JK mode with J=1 while raising the pair clock in that same cycle, and expects 0 afterwards, because the clear wins. The long sweep covers the same collision by changing the mode under random stimulus at fixed intervals. It also sets up set/reset with both inputs high, the other contested case. Every cycle, the bench compares all four nets of both pairs against a behavioural model.

// File: rtl/lut_pair_seq_pkg.sv
package lut_pair_seq_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SEQ_OFF  = 3'd0,
    SEQ_DFF  = 3'd1,
    SEQ_JK   = 3'd2,
    SEQ_DLAT = 3'd3,
    SEQ_RS   = 3'd4
  } seqMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrState;
    logic clkRise;
    logic useDff;
    logic useJk;
    logic useDlat;
    logic useRs;
  } seqStrobe_t;

endpackage

// File: rtl/lut_pair_seq_ctrl.sv
module lut_pair_seq_ctrl
  import lut_pair_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              lutClk,
  output seqStrobe_t        strobe,
  output logic              active
);

  logic              lutClkQ;
  logic [MODE_W-1:0] modeQ;

  // previous pair-clock level and previous mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lutClkQ <= 1'b1;
      modeQ   <= '0;
    end else begin
      lutClkQ <= lutClk;
      modeQ   <= mode;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clkRise  = lutClk & ~lutClkQ;
    strobe.clrState = (mode != modeQ);
    unique case (mode)
      SEQ_DFF:  strobe.useDff  = 1'b1;
      SEQ_JK:   strobe.useJk   = 1'b1;
      SEQ_DLAT: strobe.useDlat = 1'b1;
      SEQ_RS:   strobe.useRs   = 1'b1;
      default:  ;
    endcase
    active = strobe.useDff | strobe.useJk | strobe.useDlat | strobe.useRs;
  end

  AST_RISE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clkRise |=> !strobe.clkRise); // R11

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.useDff, strobe.useJk, strobe.useDlat, strobe.useRs})); // R7

endmodule

// File: rtl/lut_pair_seq_dp.sv
module lut_pair_seq_dp
  import lut_pair_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seqStrobe_t strobe,
  input  logic       active,
  input  logic       evenIn,
  input  logic       oddIn,
  output logic       routeOut
);

  logic state;
  logic stateNext;
  logic elemOut;
  logic setOnly;
  logic clrOnly;

  assign setOnly = evenIn & ~oddIn;
  assign clrOnly = oddIn & ~evenIn;

  always_comb begin
    stateNext = state;
    if (strobe.clrState) begin
      stateNext = 1'b0;
    end else if (strobe.useDff) begin
      if (strobe.clkRise && oddIn) stateNext = evenIn;
    end else if (strobe.useJk) begin
      if (strobe.clkRise) begin
        unique case ({evenIn, oddIn})
          2'b10:   stateNext = 1'b1;
          2'b01:   stateNext = 1'b0;
          2'b11:   stateNext = ~state;
          default: stateNext = state;
        endcase
      end
    end else if (strobe.useDlat) begin
      if (oddIn) stateNext = evenIn;
    end else if (strobe.useRs) begin
      if (setOnly)      stateNext = 1'b1;
      else if (clrOnly) stateNext = 1'b0;
    end else begin
      stateNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= 1'b0;
    else        state <= stateNext;
  end

  // latch kinds pass inputs straight through while transparent
  always_comb begin
    elemOut = state;
    if (strobe.useDlat && oddIn)  elemOut = evenIn;
    else if (strobe.useRs) begin
      if (setOnly)      elemOut = 1'b1;
      else if (clrOnly) elemOut = 1'b0;
    end
  end

  assign routeOut = active ? elemOut : evenIn;

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrState |=> (state == 1'b0)); // R9

  AST_DFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.useDff && !strobe.clrState && !(strobe.clkRise && oddIn))
      |=> (state == $past(state))); // R2

  AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.useJk && !strobe.clrState && strobe.clkRise && evenIn && oddIn)
      |=> (state != $past(state))); // R3

  AST_RS_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.useRs && !strobe.clrState && evenIn && oddIn)
      |=> (state == $past(state))); // R6

endmodule

// File: rtl/lut_pair_seq.sv
module lut_pair_seq
  import lut_pair_seq_pkg::*;
#(
  parameter int PAIR_COUNT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [MODE_W*PAIR_COUNT-1:0] seqMode,
  input  logic [PAIR_COUNT-1:0]        evenLut,
  input  logic [PAIR_COUNT-1:0]        oddLut,
  input  logic [PAIR_COUNT-1:0]        lutClk,
  output logic [PAIR_COUNT-1:0]        pinOut,
  output logic [PAIR_COUNT-1:0]        fbOut,
  output logic [PAIR_COUNT-1:0]        linkOut,
  output logic [PAIR_COUNT-1:0]        evtOut
);

  logic [PAIR_COUNT-1:0] route;

  for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_pair
    seqStrobe_t strobe;
    logic       active;

    lut_pair_seq_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (seqMode[MODE_W*p +: MODE_W]),
      .lutClk (lutClk[p]),
      .strobe (strobe),
      .active (active)
    );

    lut_pair_seq_dp u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .active   (active),
      .evenIn   (evenLut[p]),
      .oddIn    (oddLut[p]),
      .routeOut (route[p])
    );
  end

  // one element result feeds every downstream net (R8)
  assign pinOut  = route;
  assign fbOut   = route;
  assign linkOut = route;
  assign evtOut  = route;

endmodule

// File: tb/lut_pair_seq_test.sv
`timescale 1ns/1ps
module lut_pair_seq_test;

  localparam int P = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3*P-1:0] seqMode = '0;
  logic [P-1:0] evenLut = '0;
  logic [P-1:0] oddLut = '0;
  logic [P-1:0] lutClk = '0;
  logic [P-1:0] pinOut, fbOut, linkOut, evtOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic       mState [P];
  logic       mPrevClk [P];
  logic [2:0] mPrevMode [P];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  lut_pair_seq #(.PAIR_COUNT(P)) uut (
    .clk(clk), .rst_n(rst_n), .seqMode(seqMode), .evenLut(evenLut),
    .oddLut(oddLut), .lutClk(lutClk), .pinOut(pinOut), .fbOut(fbOut),
    .linkOut(linkOut), .evtOut(evtOut)
  );

  function automatic logic expOut(input logic [2:0] m, input logic e,
                                  input logic o, input logic st);
    case (m)
      3'd1, 3'd2: return st;
      3'd3:       return o ? e : st;
      3'd4:       return (e && !o) ? 1'b1 : ((o && !e) ? 1'b0 : st);
      default:    return e;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] m);
    case (m)
      3'd1: return "R2 R11 R8";
      3'd2: return "R3 R8";
      3'd3: return "R4 R8";
      3'd4: return "R5 R8";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] nextRng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < P; p++) begin
      mState[p] = 1'b0; mPrevClk[p] = 1'b1; mPrevMode[p] = 3'd0;
    end
  endtask

  // drive one cycle, check all nets of all pairs, advance the model
  task automatic cycle(input logic [2:0] m0, input logic e0, input logic o0,
                       input logic c0, input logic [2:0] m1, input logic e1,
                       input logic o1, input logic c1, input string tag0);
    logic [2:0] m [P];
    logic ev [P];
    logic od [P];
    logic ck [P];
    @(negedge clk);
    m[0] = m0; ev[0] = e0; od[0] = o0; ck[0] = c0;
    m[1] = m1; ev[1] = e1; od[1] = o1; ck[1] = c1;
    for (int p = 0; p < P; p++) begin
      seqMode[3*p +: 3] = m[p];
      evenLut[p] = ev[p]; oddLut[p] = od[p]; lutClk[p] = ck[p];
    end
    #1;
    for (int p = 0; p < P; p++) begin
      logic x;
      logic [3:0] got;
      string t;
      x = expOut(m[p], ev[p], od[p], mState[p]);
      got = {pinOut[p], fbOut[p], linkOut[p], evtOut[p]};
      t = (p == 0 && tag0 != "") ? tag0 : {tagFor(m[p]), " R10"};
      checks++;
      if (got !== {4{x}}) begin
        fails++;
        $display("FAIL %s pair%0d mode=%0d got=%b expected=%b", t, p, m[p], got, {4{x}});
      end
    end
    @(posedge clk);
    for (int p = 0; p < P; p++) begin
      logic rise;
      rise = ck[p] && !mPrevClk[p];
      if (m[p] != mPrevMode[p]) mState[p] = 1'b0;
      else begin
        case (m[p])
          3'd1: if (rise && od[p]) mState[p] = ev[p];
          3'd2: if (rise) begin
                  if (ev[p] && !od[p]) mState[p] = 1'b1;
                  else if (!ev[p] && od[p]) mState[p] = 1'b0;
                  else if (ev[p] && od[p]) mState[p] = ~mState[p];
                end
          3'd3: if (od[p]) mState[p] = ev[p];
          3'd4: if (ev[p] && !od[p]) mState[p] = 1'b1;
                else if (od[p] && !ev[p]) mState[p] = 1'b0;
          default: mState[p] = 1'b0;
        endcase
      end
      mPrevMode[p] = m[p];
      mPrevClk[p] = ck[p];
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: flip-flop mode straight out of reset reads 0
    cycle(3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R1");
    cycle(3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, "R1");

    // R2: capture 1 with gate high, R11 then held clock gives no capture
    cycle(3'd1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, "R2");
    cycle(3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, "R2");
    cycle(3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R11");
    // edge with gate low: hold
    cycle(3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R2");
    cycle(3'd1, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R2");
    cycle(3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R2");

    // R9: switch to JK with J=1 and a rising edge in the same cycle: clear wins
    cycle(3'd2, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R9");
    cycle(3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R9");
    // R3: toggle twice
    cycle(3'd2, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    cycle(3'd2, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    cycle(3'd2, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    cycle(3'd2, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R3");

    // R5/R6: set, then both high holds 1
    cycle(3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R9");
    cycle(3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R5");
    cycle(3'd4, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R6");
    cycle(3'd4, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R6");
    cycle(3'd4, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R5");
    cycle(3'd4, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R6");

    // R4: latch transparent then holding
    cycle(3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R4");
    cycle(3'd3, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R4");
    cycle(3'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R4");

    // sweep every mode code with pseudo-random stimulus on both pairs
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 48; k++) begin
        rng = nextRng(rng);
        cycle(3'(m), rng[0], rng[1], rng[2], 3'((m + 3 + (k / 16)) % 8),
              rng[3], rng[4], rng[5], "");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule